// File: doc/BRIEF.md
# Banked Data Register Store with Write-Busy Window

This block holds sixteen 8-bit data registers arranged as four banks of four, standing in for a nonvolatile store behind a digitally controlled potentiometer. A command front end presents one strobe per operation: a direct write, a direct read, a load of a register into the wiper counter, or a store of the wiper counter into a register. A bank index and a register index select the target. Every register can be read and written directly. Only bank 0 takes part in the two wiper transfers.

Each accepted write to the store opens a busy window that models the long program time of a real cell. Its length is a parameter counted in system clock cycles. While the window is open, every further command is refused. A write-protect input, active low, blocks both kinds of store write. A blocked write leaves the contents unchanged and does not open a busy window. The content of bank 0, register 0 is always presented as the power-up wiper position.

Top module: `nvbank`

## Requirements
- R1: A register is selected by the pair {bank_i, reg_i}. Any of the 16 registers can be read. One cycle after an accepted read strobe, rd_valid_o pulses for one cycle and rd_data_o carries that register's value.
- R2: An accepted write (wr_en_i) stores wr_data_i into the selected register, in any bank. A later read of that register returns the new value.
- R3: An accepted write or wiper store raises busy_o at the same clock edge. busy_o then stays high for exactly BUSY_CYCLES cycles and clears on the edge where the countdown expires.
- R4: While busy_o is high, every strobe is refused. One cycle later reject_o pulses, no valid output pulses, and the register contents do not change.
- R5: While wp_n_i is low, direct writes and wiper stores are refused. reject_o pulses, busy_o stays low, and the register contents do not change.
- R6: A load strobe (load_i) with bank_i = 0 returns the selected register on ld_data_o, with ld_valid_o pulsing one cycle later. With a nonzero bank the load is refused with reject_o.
- R7: A store strobe (store_i) with bank_i = 0 writes wiper_i into the selected register and starts the busy window. With a nonzero bank the store is refused with reject_o, and busy_o stays low.
- R8: dflt_o always shows bank 0, register 0. After reset it equals RESET_POS, and all other registers read 0.
- R9: When several strobes arrive in one cycle, only one is executed, in this priority: write first, then store, then load, then read.
- R10: At most one of rd_valid_o, ld_valid_o and reject_o is high in any cycle. All three are low after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_i | input | 2 | Bank index |
| reg_i | input | 2 | Register index within the bank |
| wr_en_i | input | 1 | Direct write strobe |
| wr_data_i | input | 8 | Direct write data |
| rd_en_i | input | 1 | Direct read strobe |
| load_i | input | 1 | Register-to-wiper load strobe |
| store_i | input | 1 | Wiper-to-register store strobe |
| wiper_i | input | 8 | Current wiper counter value used by a store |
| wp_n_i | input | 1 | Write protect, low blocks store writes |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid pulse |
| ld_data_o | output | 8 | Value loaded into the wiper |
| ld_valid_o | output | 1 | Load data valid pulse |
| reject_o | output | 1 | Command refused pulse |
| busy_o | output | 1 | Store write in progress |
| dflt_o | output | 8 | Power-up wiper position (bank 0, register 0) |

## Verification
The block decides on a command at the clock edge that samples its strobe. busy_o and the register contents change at that same edge. rd_valid_o, ld_valid_o, reject_o and their data become valid one register stage later, in the following cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and samples every output on the next falling edge. Its model counts the busy window edge by edge, so the bench checks both the cycle in which busy_o clears and a strobe issued in the last busy cycle. Every step also compares dflt_o with the model, which shows that refused writes and refused stores leave the contents unchanged.

// File: rtl/nvbank_pkg.sv
package nvbank_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_STORE,
        CMD_LOAD,
        CMD_READ
    } cmd_e;
endpackage

// File: rtl/nvbank_decode.sv
module nvbank_decode
    import nvbank_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              wr_en,
    input  logic              store,
    input  logic              load,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] bank,
    input  logic              busy,
    input  logic              wp_n,
    output cmd_e              cmd,
    output logic              accept,
    output logic              refuse,
    output logic              nv_we
);
    logic bank0;
    assign bank0 = (bank == '0);

    always_comb begin
        if (wr_en)      cmd = CMD_WRITE;
        else if (store) cmd = CMD_STORE;
        else if (load)  cmd = CMD_LOAD;
        else if (rd_en) cmd = CMD_READ;
        else            cmd = CMD_NONE;

        unique case (cmd)
            CMD_WRITE: accept = !busy && wp_n;
            CMD_STORE: accept = !busy && wp_n && bank0;
            CMD_LOAD:  accept = !busy && bank0;
            CMD_READ:  accept = !busy;
            default:   accept = 1'b0;
        endcase

        refuse = (cmd != CMD_NONE) && !accept;
        nv_we  = accept && ((cmd == CMD_WRITE) || (cmd == CMD_STORE));
    end
endmodule

// File: rtl/nvbank_timer.sv
module nvbank_timer #(
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(BUSY_CYCLES - 1);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
endmodule

// File: rtl/nvbank_array.sv
module nvbank_array #(
    parameter int              DATA_W    = 8,
    parameter int              DEPTH     = 16,
    parameter logic [DATA_W-1:0] RESET_POS = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        dflt
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [DATA_W-1:0] INIT = (i == 0) ? RESET_POS : '0;
        logic [DATA_W-1:0] cell_d;
        always_comb begin
            cell_d = mem_q[i];
            if (we && (addr == i)) cell_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= INIT;
            else        mem_q[i] <= cell_d;
        end
    end

    assign rdata = mem_q[addr];
    assign dflt  = mem_q[0];
endmodule

// File: rtl/nvbank.sv
module nvbank
    import nvbank_pkg::*;
#(
    parameter int              BANKS       = 4,
    parameter int              REGS        = 4,
    parameter int              DATA_W      = 8,
    parameter int              BUSY_CYCLES = 1250000,
    parameter logic [7:0]      RESET_POS   = 8'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BANKS)-1:0]  bank_i,
    input  logic [$clog2(REGS)-1:0]   reg_i,
    input  logic                      wr_en_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic                      rd_en_i,
    input  logic                      load_i,
    input  logic                      store_i,
    input  logic [DATA_W-1:0]         wiper_i,
    input  logic                      wp_n_i,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      rd_valid_o,
    output logic [DATA_W-1:0]         ld_data_o,
    output logic                      ld_valid_o,
    output logic                      reject_o,
    output logic                      busy_o,
    output logic [DATA_W-1:0]         dflt_o
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int REG_W  = $clog2(REGS);
    localparam int DEPTH  = BANKS * REGS;
    localparam int ADDR_W = BANK_W + REG_W;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
        logic [DATA_W-1:0] ld_data;
        logic              ld_valid;
        logic              reject;
    } resp_t;

    resp_t resp_d, resp_q;

    cmd_e              cmd;
    logic              accept, refuse, nv_we, busy;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata, dflt;

    assign addr  = {bank_i, reg_i};
    assign wdata = (cmd == CMD_STORE) ? wiper_i : wr_data_i;

    nvbank_decode #(.BANK_W(BANK_W)) u_dec (
        .wr_en  (wr_en_i),
        .store  (store_i),
        .load   (load_i),
        .rd_en  (rd_en_i),
        .bank   (bank_i),
        .busy   (busy),
        .wp_n   (wp_n_i),
        .cmd    (cmd),
        .accept (accept),
        .refuse (refuse),
        .nv_we  (nv_we)
    );

    nvbank_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_we),
        .busy  (busy)
    );

    nvbank_array #(
        .DATA_W    (DATA_W),
        .DEPTH     (DEPTH),
        .RESET_POS (DATA_W'(RESET_POS))
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (nv_we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .dflt  (dflt)
    );

    always_comb begin
        resp_d          = resp_q;
        resp_d.rd_valid = accept && (cmd == CMD_READ);
        resp_d.ld_valid = accept && (cmd == CMD_LOAD);
        resp_d.reject   = refuse;
        if (resp_d.rd_valid) resp_d.rd_data = rdata;
        if (resp_d.ld_valid) resp_d.ld_data = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rd_data_o  = resp_q.rd_data;
    assign rd_valid_o = resp_q.rd_valid;
    assign ld_data_o  = resp_q.ld_data;
    assign ld_valid_o = resp_q.ld_valid;
    assign reject_o   = resp_q.reject;
    assign busy_o     = busy;
    assign dflt_o     = dflt;
endmodule

// File: rtl/nvbank_checker.sv
module nvbank_checker #(
    parameter int BANK_W      = 2,
    parameter int BUSY_CYCLES = 1250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANK_W-1:0] bank_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              load_i,
    input logic              store_i,
    input logic              wp_n_i,
    input logic              rd_valid_o,
    input logic              ld_valid_o,
    input logic              reject_o,
    input logic              busy_o
);
    localparam int RUN_W = $clog2(BUSY_CYCLES + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    assert_write_opens_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wp_n_i && !busy_o) |=> busy_o);

    assert_busy_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(BUSY_CYCLES));

    assert_busy_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (wr_en_i || rd_en_i || load_i || store_i)) |=> (reject_o && !rd_valid_o && !ld_valid_o));

    assert_protect_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !wp_n_i) |=> !busy_o);

    assert_load_bank0_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !wr_en_i && !store_i && bank_i != '0) |=> (!ld_valid_o && reject_o));

    assert_store_bank0_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !wr_en_i && !busy_o && bank_i != '0) |=> !busy_o);

    assert_resp_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid_o, ld_valid_o, reject_o}));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i || rd_en_i || load_i || store_i) |=> !(rd_valid_o || ld_valid_o || reject_o));
endmodule

bind nvbank nvbank_checker #(
    .BANK_W      ($clog2(BANKS)),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_i     (bank_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .load_i     (load_i),
    .store_i    (store_i),
    .wp_n_i     (wp_n_i),
    .rd_valid_o (rd_valid_o),
    .ld_valid_o (ld_valid_o),
    .reject_o   (reject_o),
    .busy_o     (busy_o)
);

// File: tb/nvbank_tb.sv
module nvbank_tb;
    localparam int         NB   = 12;
    localparam logic [7:0] RPOS = 8'h80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_i = '0, reg_i = '0;
    logic       wr_en_i = 0, rd_en_i = 0, load_i = 0, store_i = 0, wp_n_i = 1;
    logic [7:0] wr_data_i = '0, wiper_i = '0;
    logic [7:0] rd_data_o, ld_data_o, dflt_o;
    logic       rd_valid_o, ld_valid_o, reject_o, busy_o;

    int tests = 0, fails = 0;
    logic [7:0] mdl [16];
    int mbusy = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nvbank #(.BUSY_CYCLES(NB), .RESET_POS(RPOS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bank_i(bank_i), .reg_i(reg_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .load_i(load_i), .store_i(store_i), .wiper_i(wiper_i), .wp_n_i(wp_n_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .ld_data_o(ld_data_o),
        .ld_valid_o(ld_valid_o), .reject_o(reject_o), .busy_o(busy_o), .dflt_o(dflt_o)
    );

    task automatic step(input logic w, s, l, r, input logic [1:0] b, rg,
                        input logic [7:0] d, wip, input logic wpn, input string tag);
        logic ev_r, ev_l, ev_j, ok, bsy;
        logic [7:0] ed;
        int a;
        wr_en_i = w; store_i = s; load_i = l; rd_en_i = r;
        bank_i = b; reg_i = rg; wr_data_i = d; wiper_i = wip; wp_n_i = wpn;
        @(posedge clk);
        a = {b, rg};
        bsy = (mbusy > 0);
        if (mbusy > 0) mbusy--;
        ev_r = 0; ev_l = 0; ev_j = 0; ed = '0;
        if (w) begin
            ok = !bsy && wpn;
            if (ok) begin mdl[a] = d; mbusy = NB; end else ev_j = 1;
        end else if (s) begin
            ok = !bsy && wpn && (b == 0);
            if (ok) begin mdl[a] = wip; mbusy = NB; end else ev_j = 1;
        end else if (l) begin
            ok = !bsy && (b == 0);
            if (ok) begin ev_l = 1; ed = mdl[a]; end else ev_j = 1;
        end else if (r) begin
            if (!bsy) begin ev_r = 1; ed = mdl[a]; end else ev_j = 1;
        end
        @(negedge clk);
        tests++;
        if (rd_valid_o !== ev_r || ld_valid_o !== ev_l || reject_o !== ev_j ||
            busy_o !== (mbusy > 0) || dflt_o !== mdl[0] ||
            (ev_r && rd_data_o !== ed) || (ev_l && ld_data_o !== ed)) begin
            fails++;
            $display("FAIL %s: got rv=%b lv=%b rej=%b busy=%b rd=%h ld=%h dflt=%h exp rv=%b lv=%b rej=%b busy=%b data=%h dflt=%h",
                     tag, rd_valid_o, ld_valid_o, reject_o, busy_o, rd_data_o, ld_data_o, dflt_o,
                     ev_r, ev_l, ev_j, (mbusy > 0), ed, mdl[0]);
        end
        wr_en_i = 0; store_i = 0; load_i = 0; rd_en_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'd0, 2'd0, 8'h00, 8'h00, 1'b1, "R3");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        mdl[0] = RPOS;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (busy_o !== 0 || rd_valid_o !== 0 || ld_valid_o !== 0 || reject_o !== 0 || dflt_o !== RPOS) begin
            fails++;
            $display("FAIL R8: reset state busy=%b dflt=%h exp busy=0 dflt=%h", busy_o, dflt_o, RPOS);
        end
        // R8 / R1: other registers read zero after reset
        step(0, 0, 0, 1, 2'd3, 2'd2, 0, 0, 1, "R8");
        step(0, 0, 0, 1, 2'd0, 2'd0, 0, 0, 1, "R1");
        // R2 / R3: write bank 2 reg 3, busy for exactly NB cycles
        step(1, 0, 0, 0, 2'd2, 2'd3, 8'h5A, 0, 1, "R2");
        idle(NB - 1);
        // R4: strobe in the last busy cycle is refused
        step(0, 0, 0, 1, 2'd2, 2'd3, 0, 0, 1, "R4");
        step(0, 0, 0, 1, 2'd2, 2'd3, 0, 0, 1, "R2");
        // R4: write while busy leaves contents
        step(1, 0, 0, 0, 2'd1, 2'd1, 8'h11, 0, 1, "R2");
        step(1, 0, 0, 0, 2'd1, 2'd1, 8'h22, 0, 1, "R4");
        idle(NB);
        step(0, 0, 0, 1, 2'd1, 2'd1, 0, 0, 1, "R4");
        // R5: write protect blocks write and store
        step(1, 0, 0, 0, 2'd0, 2'd0, 8'h33, 0, 0, "R5");
        step(0, 1, 0, 0, 2'd0, 2'd0, 0, 8'h44, 0, "R5");
        step(0, 0, 0, 1, 2'd0, 2'd0, 0, 0, 0, "R5");
        // R7: store from wiper, bank 0 vs bank 1
        step(0, 1, 0, 0, 2'd1, 2'd2, 0, 8'h66, 1, "R7");
        step(0, 1, 0, 0, 2'd0, 2'd0, 0, 8'h77, 1, "R7");
        idle(NB);
        // R6: load bank 0 and refused load bank 3
        step(0, 0, 1, 0, 2'd0, 2'd0, 0, 0, 1, "R6");
        step(0, 0, 1, 0, 2'd3, 2'd0, 0, 0, 1, "R6");
        // R9: all strobes at once -> write wins
        step(1, 1, 1, 1, 2'd0, 2'd2, 8'h9C, 8'h01, 1, "R9");
        idle(NB);
        // R9: load beats read
        step(0, 0, 1, 1, 2'd0, 2'd2, 0, 0, 1, "R9");
        // R9 / R10: store with bad bank beats read
        step(0, 1, 0, 1, 2'd2, 2'd2, 0, 8'h02, 1, "R10");
        // random phase
        void'($urandom(32'd4242));
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom % 16;
            step(k == 0, k == 1, k == 2 || k == 3, k >= 4 && k <= 6,
                 2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
                 ($urandom % 6) != 0, "R10");
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got hung run exp completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule